// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is one FIFO channel that holds 256 words of 9 bits. Words enter on the rising edge of a write clock and leave on the rising edge of a read clock. The two clocks may be unrelated, or they may be the same clock. Pointers cross between the two domains as Gray-code values through two-flop synchronizers. As a result, a flag can clear a little later than the event that clears it, but it never clears early.

The write side has two enables. The second one also serves as a load strobe. Its level while reset is held selects how the channel behaves until the next reset:
- **Two-enable mode.** Both enables qualify each write, which suits depth expansion.
- **Threshold-programming mode.** The first enable alone governs traffic. The second input, when low, loads new almost-empty and almost-full thresholds from a pair of offset input buses.

A read needs both read enables. The read updates a registered output. A separate output-enable input produces a drive indication in place of a tri-state pad. All four flags are active low.

Top module: `dual_clk_fifo`

## Requirements
- R1: While `rstN` is low, both pointers return to word 0, so the FIFO is empty. `rdData` is cleared to 0, and both thresholds return to their defaults (empty threshold 7, full threshold 7).
- R2: While `rstN` is low, `fullN` and `almostFullN` are 1, and `emptyN` and `almostEmptyN` are 0.
- R3: If `wrEn2Load` is 1 on the write-clock edges during reset, the channel is in two-enable mode. A word is stored only when `wrEn1N`=0 and `wrEn2Load`=1. No input combination changes the thresholds.
- R4: If `wrEn2Load` is 0 on the write-clock edges during reset, the channel is in threshold-programming mode:
  - `wrEn1N`=0 with `wrEn2Load`=1 stores a word.
  - `wrEn1N`=0 with `wrEn2Load`=0 copies `ofsEmptyIn` and `ofsFullIn` into the thresholds and stores no word.
- R5: On a rising `rdClk`, the next word is copied into `rdData` only when `rdEn1N`=0 and `rdEn2N`=0. In every other case `rdData` keeps its value.
- R6: Write requests are ignored while `fullN`=0. Read requests are ignored while `emptyN`=0, and `rdData` then holds.
- R7: Words come out in the order they were written. Up to 256 words can be held. This holds with unrelated clocks and with one shared clock, including reads and writes in the same cycle at the empty and full boundaries.
- R8: `almostEmptyN` is 0 exactly when the word count seen by the read domain is at or below the empty threshold. `emptyN` is 0 exactly when that count is 0.
- R9: `almostFullN` is 0 exactly when the free space seen by the write domain is at or below the full threshold. `fullN` is 0 exactly when 256 words are held.
- R10: `dataDrive` equals the inverse of `outEnN`. `outEnN` has no effect on `rdData`.
- R11: When both ports run on one clock and the FIFO is empty, a write on edge k leaves `emptyN` at 0 after edges k and k+1. `emptyN` becomes 1 after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| wrData | input | 9 | Word to store |
| wrEn1N | input | 1 | First write enable, active low |
| wrEn2Load | input | 1 | Second write enable or threshold load strobe, sampled in reset |
| ofsEmptyIn | input | 8 | Almost-empty threshold to load |
| ofsFullIn | input | 8 | Almost-full threshold to load |
| rdEn1N | input | 1 | First read enable, active low |
| rdEn2N | input | 1 | Second read enable, active low |
| outEnN | input | 1 | Output enable, active low |
| rdData | output | 9 | Registered read word |
| dataDrive | output | 1 | High when the output would be driven |
| fullN | output | 1 | Full flag, active low, write-clock domain |
| almostFullN | output | 1 | Almost-full flag, active low, write-clock domain |
| emptyN | output | 1 | Empty flag, active low, read-clock domain |
| almostEmptyN | output | 1 | Almost-empty flag, active low, read-clock domain |

## Verification
A write pointer that is off by one, or a Gray conversion that is wrong, shows up as a mismatched word. The scoreboard reports it on the first read after the fault, one read-clock cycle after the pop. A wrong count shows up directly in the flags: a shifted threshold flips `almostEmptyN` or `almostFullN` at the wrong fill level, on the edge where that level is reached. A mode latch or threshold register that is lost is exposed after reset, when a disabled write stores a word or the default threshold does not hold. Synchronizer latency errors are measured edge by edge, with both ports on one clock.

// File: rtl/dual_clk_fifo_pkg.sv
`timescale 1ns/1ps
package dual_clk_fifo_pkg;
  // Strobes from control to datapath: push on wrClk, pop on rdClk,
  // threshold load on wrClk.
  typedef struct packed {
    logic push;
    logic pop;
    logic ofsLoad;
  } fifo_strobe_t;
endpackage

// File: rtl/dual_clk_fifo_sync.sv
`timescale 1ns/1ps
module dual_clk_fifo_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s+1] <= '0;
      else       chain[s+1] <= chain[s];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/dual_clk_fifo_ctrl.sv
`timescale 1ns/1ps
module dual_clk_fifo_ctrl
  import dual_clk_fifo_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn1N,
  input  logic              wrEn2Load,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  input  logic [ADDR_W-1:0] emptyOfs,
  input  logic [ADDR_W-1:0] fullOfs,
  output fifo_strobe_t      strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullN,
  output logic              almostFullN,
  output logic              emptyN,
  output logic              almostEmptyN
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] CAPACITY = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [PW-1:0] ONE      = PW'(1);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          flagMode;
  logic [PW-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PW-1:0] rdGraySyncW, wrGraySyncR;
  logic [PW-1:0] wrUsed, wrFree, rdUsed;
  logic          wrReq, wrFull, rdEmpty, pushNow, popNow, loadNow;

  // Mode is captured on every write-clock edge while reset is held.
  always_ff @(posedge wrClk) begin
    if (!rstN) flagMode <= !wrEn2Load;
  end

  // ---------------- write domain ----------------
  assign wrReq   = !wrEn1N && wrEn2Load;
  assign loadNow = flagMode && !wrEn1N && !wrEn2Load;
  assign wrUsed  = wrBin - fromGray(rdGraySyncW);
  assign wrFree  = CAPACITY - wrUsed;
  assign wrFull  = (wrUsed == CAPACITY);
  assign pushNow = wrReq && !wrFull;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (pushNow) begin
      wrBin  <= wrBin + ONE;
      wrGray <= toGray(wrBin + ONE);
    end
  end

  dual_clk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk (wrClk),
    .rstN(rstN),
    .d   (rdGray),
    .q   (rdGraySyncW)
  );

  // ---------------- read domain ----------------
  assign rdUsed  = fromGray(wrGraySyncR) - rdBin;
  assign rdEmpty = (rdUsed == '0);
  assign popNow  = !rdEn1N && !rdEn2N && !rdEmpty;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (popNow) begin
      rdBin  <= rdBin + ONE;
      rdGray <= toGray(rdBin + ONE);
    end
  end

  dual_clk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk (rdClk),
    .rstN(rstN),
    .d   (wrGray),
    .q   (wrGraySyncR)
  );

  // ---------------- outputs ----------------
  always_comb begin
    strb.push    = pushNow;
    strb.pop     = popNow;
    strb.ofsLoad = loadNow;
  end

  assign wrAddr       = wrBin[ADDR_W-1:0];
  assign rdAddr       = rdBin[ADDR_W-1:0];
  assign fullN        = !wrFull;
  assign almostFullN  = !(wrFree <= {1'b0, fullOfs});
  assign emptyN       = !rdEmpty;
  assign almostEmptyN = !(rdUsed <= {1'b0, emptyOfs});
endmodule

// File: rtl/dual_clk_fifo_dpath.sv
`timescale 1ns/1ps
module dual_clk_fifo_dpath
  import dual_clk_fifo_pkg::*;
#(
  parameter int DATA_W        = 9,
  parameter int ADDR_W        = 8,
  parameter int EMPTY_OFS_DEF = 7,
  parameter int FULL_OFS_DEF  = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifo_strobe_t      strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] ofsEmptyIn,
  input  logic [ADDR_W-1:0] ofsFullIn,
  input  logic              outEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              dataDrive,
  output logic [ADDR_W-1:0] emptyOfs,
  output logic [ADDR_W-1:0] fullOfs
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.push) mem[wrAddr] <= wrData;
  end

  // Thresholds live in the write domain; the read side treats emptyOfs
  // as quasi-static.
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      emptyOfs <= ADDR_W'(EMPTY_OFS_DEF);
      fullOfs  <= ADDR_W'(FULL_OFS_DEF);
    end else if (strb.ofsLoad) begin
      emptyOfs <= ofsEmptyIn;
      fullOfs  <= ofsFullIn;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (strb.pop) rdData <= mem[rdAddr];
  end

  assign dataDrive = !outEnN;
endmodule

// File: rtl/dual_clk_fifo.sv
`timescale 1ns/1ps
module dual_clk_fifo
  import dual_clk_fifo_pkg::*;
#(
  parameter int DATA_W        = 9,
  parameter int ADDR_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int EMPTY_OFS_DEF = 7,
  parameter int FULL_OFS_DEF  = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn1N,
  input  logic              wrEn2Load,
  input  logic [ADDR_W-1:0] ofsEmptyIn,
  input  logic [ADDR_W-1:0] ofsFullIn,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  input  logic              outEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              dataDrive,
  output logic              fullN,
  output logic              almostFullN,
  output logic              emptyN,
  output logic              almostEmptyN
);
  fifo_strobe_t      strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr, emptyOfs, fullOfs;

  dual_clk_fifo_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .wrEn1N      (wrEn1N),
    .wrEn2Load   (wrEn2Load),
    .rdEn1N      (rdEn1N),
    .rdEn2N      (rdEn2N),
    .emptyOfs    (emptyOfs),
    .fullOfs     (fullOfs),
    .strb        (strb),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .fullN       (fullN),
    .almostFullN (almostFullN),
    .emptyN      (emptyN),
    .almostEmptyN(almostEmptyN)
  );

  dual_clk_fifo_dpath #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .EMPTY_OFS_DEF(EMPTY_OFS_DEF),
    .FULL_OFS_DEF (FULL_OFS_DEF)
  ) u_dpath (
    .wrClk     (wrClk),
    .rdClk     (rdClk),
    .rstN      (rstN),
    .strb      (strb),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr),
    .wrData    (wrData),
    .ofsEmptyIn(ofsEmptyIn),
    .ofsFullIn (ofsFullIn),
    .outEnN    (outEnN),
    .rdData    (rdData),
    .dataDrive (dataDrive),
    .emptyOfs  (emptyOfs),
    .fullOfs   (fullOfs)
  );
endmodule

// File: rtl/dual_clk_fifo_chk.sv
`timescale 1ns/1ps
module dual_clk_fifo_chk #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              rdEn1N,
  input logic              rdEn2N,
  input logic [DATA_W-1:0] rdData,
  input logic              fullN,
  input logic              almostFullN,
  input logic              emptyN,
  input logic              almostEmptyN,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              pushS,
  input logic              popS
);
  // R2: flag levels while reset is held
  always @(negedge wrClk) begin
    if (rstN === 1'b0) begin
      a_r2_reset_flags: assert (fullN && almostFullN && !emptyN && !almostEmptyN)
        else $error("reset flag levels wrong");
    end
  end

  // R6: a full FIFO does not advance its write address
  a_r6_no_write_when_full: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> $stable(wrAddr));

  // R6: an empty FIFO keeps its output word
  a_r6_hold_when_empty: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(rdData));

  // R5: a single read enable is not enough
  a_r5_hold_without_both: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn1N || rdEn2N) |=> $stable(rdData));

  // R9: full is always also almost-full
  a_r9_full_is_almost_full: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !almostFullN);

  // R8: empty is always also almost-empty
  a_r8_empty_is_almost_empty: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN);

  // R7: each push and pop moves its address by exactly one
  a_r7_push_steps_one: assert property (@(posedge wrClk) disable iff (!rstN)
    pushS |=> wrAddr == ADDR_W'($past(wrAddr) + 1'b1));

  a_r7_pop_steps_one: assert property (@(posedge rdClk) disable iff (!rstN)
    popS |=> rdAddr == ADDR_W'($past(rdAddr) + 1'b1));
endmodule

bind dual_clk_fifo dual_clk_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wrClk       (wrClk),
  .rdClk       (rdClk),
  .rstN        (rstN),
  .rdEn1N      (rdEn1N),
  .rdEn2N      (rdEn2N),
  .rdData      (rdData),
  .fullN       (fullN),
  .almostFullN (almostFullN),
  .emptyN      (emptyN),
  .almostEmptyN(almostEmptyN),
  .wrAddr      (wrAddr),
  .rdAddr      (rdAddr),
  .pushS       (strb.push),
  .popS        (strb.pop)
);

// File: tb/tb_dual_clk_fifo.sv
`timescale 1ns/1ps
module tb_dual_clk_fifo;
  logic       wrClk = 1'b0;
  logic       rdClk = 1'b0;
  logic       rstN, wrEn1N, wrEn2Load, rdEn1N, rdEn2N, outEnN;
  logic [8:0] wrData;
  logic [7:0] ofsEmptyIn, ofsFullIn;
  logic [8:0] rdData;
  logic       dataDrive, fullN, almostFullN, emptyN, almostEmptyN;

  bit         sameClk = 1'b0;
  realtime    rdHalf  = 3.4;
  int         checks  = 0;
  int         errors  = 0;
  bit         done    = 1'b0;
  logic [8:0] nextVal = 9'd1;
  logic [8:0] sbq [$];

  dual_clk_fifo dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrData(wrData),
    .wrEn1N(wrEn1N), .wrEn2Load(wrEn2Load), .ofsEmptyIn(ofsEmptyIn),
    .ofsFullIn(ofsFullIn), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N), .outEnN(outEnN),
    .rdData(rdData), .dataDrive(dataDrive), .fullN(fullN),
    .almostFullN(almostFullN), .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  always #2 wrClk = ~wrClk;   // 250 MHz

  initial begin
    forever begin
      if (sameClk) begin
        @(wrClk);
        rdClk = wrClk;
      end else begin
        #(rdHalf);
        rdClk = ~rdClk;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic ld);
    @(negedge wrClk);
    rstN = 1'b0; wrEn2Load = ld; wrEn1N = 1'b1; rdEn1N = 1'b1; rdEn2N = 1'b1;
    repeat (4) @(negedge wrClk);
    sbq.delete();
    rstN = 1'b0;
    @(negedge wrClk);
    rstN = 1'b1; wrEn2Load = 1'b1;
  endtask

  // Driver: each accepted word goes into the scoreboard queue.
  task automatic writeBurst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrEn1N = 1'b0; wrEn2Load = 1'b1; wrData = nextVal;
      if (fullN) begin
        sbq.push_back(nextVal);
        nextVal = nextVal + 9'd1;
      end
    end
    @(negedge wrClk);
    wrEn1N = 1'b1;
  endtask

  // Monitor: pops the expected word when a read is accepted, compares after.
  task automatic readBurst(input int n);
    bit         pend = 1'b0;
    logic [8:0] exp  = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge rdClk);
      if (pend) chk(rdData === exp, "R7", "word order", rdData, exp);
      pend = 1'b0;
      rdEn1N = 1'b0; rdEn2N = 1'b0;
      if (emptyN) begin
        if (sbq.size() == 0) chk(1'b0, "R6", "read of absent word", 1, 0);
        else begin
          exp  = sbq.pop_front();
          pend = 1'b1;
        end
      end
    end
    @(negedge rdClk);
    if (pend) chk(rdData === exp, "R7", "word order", rdData, exp);
    rdEn1N = 1'b1; rdEn2N = 1'b1;
  endtask

  task automatic expectDrained(input string tag);
    repeat (6) @(negedge rdClk);
    chk(sbq.size() == 0, "R7", {tag, " words left"}, sbq.size(), 0);
    chk(emptyN == 1'b0, "R8", {tag, " emptyN"}, emptyN, 0);
  endtask

  initial begin
    #300000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] lastWord;
    int         used;
    rstN = 1'b0; wrEn1N = 1'b1; wrEn2Load = 1'b0; rdEn1N = 1'b1; rdEn2N = 1'b1;
    outEnN = 1'b0; wrData = '0; ofsEmptyIn = '0; ofsFullIn = '0;

    // ---- reset state, threshold-programming mode selected ----
    repeat (4) @(negedge wrClk);
    chk(fullN == 1'b1, "R2", "fullN in reset", fullN, 1);
    chk(almostFullN == 1'b1, "R2", "almostFullN in reset", almostFullN, 1);
    chk(emptyN == 1'b0, "R2", "emptyN in reset", emptyN, 0);
    chk(almostEmptyN == 1'b0, "R2", "almostEmptyN in reset", almostEmptyN, 0);
    chk(rdData == 9'd0, "R1", "rdData in reset", rdData, 0);
    @(negedge wrClk);
    rstN = 1'b1; wrEn2Load = 1'b1;

    // R4: load thresholds empty=3 full=5, no word stored
    @(negedge wrClk);
    ofsEmptyIn = 8'd3; ofsFullIn = 8'd5; wrEn1N = 1'b0; wrEn2Load = 1'b0;
    @(negedge wrClk);
    wrEn1N = 1'b1; wrEn2Load = 1'b1;
    repeat (6) @(negedge rdClk);
    chk(emptyN == 1'b0, "R4", "load strobe stored a word", emptyN, 0);

    writeBurst(3);
    repeat (6) @(negedge rdClk);
    chk(emptyN == 1'b1, "R8", "emptyN with 3 words", emptyN, 1);
    chk(almostEmptyN == 1'b0, "R8", "almostEmptyN at 3 words, threshold 3", almostEmptyN, 0);
    writeBurst(1);
    repeat (6) @(negedge rdClk);
    chk(almostEmptyN == 1'b1, "R8", "almostEmptyN at 4 words", almostEmptyN, 1);

    // R9: fill to 256, checking flags at each level (full threshold 5)
    used = 4;
    while (used < 256) begin
      writeBurst(1);
      used++;
      chk(almostFullN == ((256 - used) > 5), "R9", "almostFullN vs fill", almostFullN,
          int'((256 - used) > 5));
      chk(fullN == (used < 256), "R9", "fullN vs fill", fullN, int'(used < 256));
    end

    // R6: a write while full is dropped (scoreboard proves no extra word)
    writeBurst(1);
    chk(fullN == 1'b0, "R6", "fullN after write while full", fullN, 0);

    // R5: one read enable alone does nothing
    @(negedge rdClk); rdEn1N = 1'b0; rdEn2N = 1'b1;
    repeat (4) @(negedge rdClk);
    chk(rdData == 9'd0, "R5", "rdData with only enable 1", rdData, 0);
    rdEn1N = 1'b1; rdEn2N = 1'b0;
    repeat (4) @(negedge rdClk);
    chk(rdData == 9'd0, "R5", "rdData with only enable 2", rdData, 0);
    rdEn2N = 1'b1;

    readBurst(300);
    expectDrained("after fill");
    repeat (6) @(negedge wrClk);
    chk(fullN == 1'b1, "R9", "fullN after drain", fullN, 1);
    chk(almostFullN == 1'b1, "R9", "almostFullN after drain", almostFullN, 1);
    chk(almostEmptyN == 1'b0, "R8", "almostEmptyN after drain", almostEmptyN, 0);

    // R6: reads while empty leave rdData alone
    lastWord = rdData;
    @(negedge rdClk); rdEn1N = 1'b0; rdEn2N = 1'b0;
    repeat (5) @(negedge rdClk);
    chk(rdData == lastWord, "R6", "rdData on empty read", rdData, lastWord);
    rdEn1N = 1'b1; rdEn2N = 1'b1;

    // R10: output enable only changes the drive indication
    outEnN = 1'b1;
    @(negedge rdClk);
    chk(dataDrive == 1'b0, "R10", "dataDrive disabled", dataDrive, 0);
    chk(rdData == lastWord, "R10", "rdData with outEnN high", rdData, lastWord);
    outEnN = 1'b0;
    @(negedge rdClk);
    chk(dataDrive == 1'b1, "R10", "dataDrive enabled", dataDrive, 1);

    // ---- two-enable mode, one shared clock ----
    sameClk = 1'b1;
    doReset(1'b1);
    chk(rdData == 9'd0, "R1", "rdData cleared by reset", rdData, 0);
    @(negedge wrClk);
    ofsEmptyIn = 8'd0; wrEn1N = 1'b0; wrEn2Load = 1'b0;
    repeat (3) @(negedge wrClk);
    wrEn1N = 1'b1; wrEn2Load = 1'b1;
    repeat (4) @(negedge wrClk);
    chk(emptyN == 1'b0, "R3", "write with enable 2 low", emptyN, 0);

    // R11: empty deassert latency with one clock
    wrEn1N = 1'b0; wrData = nextVal;
    sbq.push_back(nextVal); nextVal = nextVal + 9'd1;
    @(negedge wrClk); wrEn1N = 1'b1;
    chk(emptyN == 1'b0, "R11", "emptyN after write edge", emptyN, 0);
    @(negedge wrClk);
    chk(emptyN == 1'b0, "R11", "emptyN one edge later", emptyN, 0);
    @(negedge wrClk);
    chk(emptyN == 1'b1, "R11", "emptyN two edges later", emptyN, 1);

    // R3 and R1: threshold stays at default 7 despite the load attempt
    writeBurst(6);
    repeat (4) @(negedge rdClk);
    chk(almostEmptyN == 1'b0, "R3", "almostEmptyN at 7 words, default 7", almostEmptyN, 0);
    writeBurst(1);
    repeat (4) @(negedge rdClk);
    chk(almostEmptyN == 1'b1, "R8", "almostEmptyN at 8 words", almostEmptyN, 1);
    readBurst(20);
    expectDrained("two-enable");

    // R7: concurrent traffic at the empty boundary, shared clock
    fork
      writeBurst(40);
      readBurst(60);
    join
    readBurst(60);
    expectDrained("shared clock");

    // ---- unrelated clocks, slow reader, full boundary ----
    rdHalf = 5.3;
    doReset(1'b0);
    sameClk = 1'b0;
    writeBurst(256);
    chk(fullN == 1'b0, "R9", "fullN after 256 writes", fullN, 0);
    fork
      writeBurst(120);
      readBurst(150);
    join
    readBurst(400);
    expectDrained("slow reader");

    // fast reader
    rdHalf = 1.7;
    fork
      writeBurst(300);
      readBurst(400);
    join
    readBurst(300);
    expectDrained("fast reader");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule